// File: doc/BRIEF.md
# Bus Controller Frame Sequencer

This block orders the bus phases of each frame for the controller side of a two-wire I3C-style bus. Control words come from a command queue. Each word describes one message: its type, its target address, its direction bit, its data length, whether it carries a target-reset-action command, and whether it closes the frame. From these words the block produces an ordered stream of phase tokens for a bit-level engine further down the chain. That engine handles pin timing and drive modes; this block does not.

A frame starts in one of two ways. Software can pulse a trigger, or it can write the first control word into an empty queue. In both cases the block raises a "control word needed" flag until the frame's last word has been taken. Configuration controls three per-frame phases: the broadcast arbitration header, the exit pattern after a header-only message, and the reset pattern before STOP. A preload mode holds the frame start until the queues report that they are filled. The controller role is fixed each time the block is enabled.

Both streams use valid/ready. A beat transfers on a clock edge where valid and ready are both high. The command side (`cmd_*`) is accepted only when `cmd_ready` is high; `cmd_ready` does not depend on `cmd_valid`. The token side (`tok_*`) holds `tok_kind` and `tok_data` steady while `tok_valid` is high and `tok_ready` is low. A low `tok_ready` stalls the sequencer with no loss.

Top module: `ctl_frame_sequencer`

## Requirements
- R1: When the no-arbitration option is clear, the first message of a frame is followed by an arbitration-header token (`tok_data` 8'hFC) right after START, but only if that message has type 4'b0010 (private transfer) or 4'b0011 (legacy two-wire transfer). No such token is emitted after a repeated START, for any other message type, or while the option is set.
- R2: Each non-header-only message emits an address token whose `tok_data` is {address[6:0], rnw}. It then emits one data token per byte of its length, and the data tokens carry indices 0, 1, 2 and so on in `tok_data`.
- R3: Messages inside one frame are separated by a repeated START token. The frame ends with a STOP token after the message tagged as message-end, and `busy` falls after that STOP transfers.
- R4: With the reset-pattern option set, a reset-pattern token comes just before STOP in any frame where some word had its reset-action bit set. Otherwise STOP follows the last message directly.
- R5: A header-only message (type 4'b0001) emits the 8'hFC header token after START. When the exit-pattern option is set, an exit-pattern token follows that header. When the option is clear, none does.
- R6: A `sw_trigger` pulse while idle raises `need_word` in the next cycle. The flag stays high until a word tagged message-end is accepted.
- R7: A `first_wr` pulse while idle, with `cmd_valid` low and `first_wr_mend` low, raises `need_word`. With `first_wr_mend` high, the flag stays low.
- R8: If no word is available when the next message of a frame must be fetched, no token is emitted, `busy` stays high, and `need_word` is high until a word arrives.
- R9: With `cfg_preload` set, a frame does not start until `cfifo_loaded` is high. A head word that writes data (rnw 0, nonzero length, not header-only) also waits for `txf_loaded`.
- R10: Option writes (`opt_wr`) take effect only while idle. A write made while `busy` is high is ignored.
- R11: The role is sampled on the rising edge of `cfg_enable`. In target role the block emits no token, holds `cmd_ready` and `need_word` low, and ignores role changes until it is re-enabled.
- R12: Token kinds are encoded as START=0, header=1, address=2, data=3, exit pattern=4, reset pattern=5, repeated START=6, STOP=7. A token that is valid but not ready keeps its kind and data until it transfers.
- R13: After reset, `busy`, `tok_valid`, `cmd_ready` and `need_word` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable |
| cfg_ctrl_role | input | 1 | Role at enable: 1 controller, 0 target |
| cfg_preload | input | 1 | Hold frame start until queues report loaded |
| opt_wr | input | 1 | Write strobe for the three frame options |
| opt_no_arb_in | input | 1 | Option: suppress arbitration header |
| opt_exit_in | input | 1 | Option: exit pattern after header-only message |
| opt_rst_in | input | 1 | Option: reset pattern before STOP |
| sw_trigger | input | 1 | Software frame trigger pulse |
| first_wr | input | 1 | Direct write of a first control word |
| first_wr_mend | input | 1 | Message-end tag of that direct write |
| cfifo_loaded | input | 1 | Command queue preloaded |
| txf_loaded | input | 1 | Transmit data queue preloaded |
| cmd_valid | input | 1 | Control word valid |
| cmd_ready | output | 1 | Control word accepted this edge when both high |
| cmd_mend | input | 1 | Word closes the frame |
| cmd_mtype | input | 4 | Message type |
| cmd_rstact | input | 1 | Word carries a target-reset-action command |
| cmd_addr | input | 7 | Target address |
| cmd_rnw | input | 1 | Direction bit, 1 = read |
| cmd_len | input | LEN_W | Data byte count |
| tok_valid | output | 1 | Token valid |
| tok_ready | input | 1 | Downstream accepts token |
| tok_kind | output | 3 | Token kind (R12 encoding) |
| tok_data | output | TOKD_W | Header/address byte or data index |
| need_word | output | 1 | Control word needed |
| busy | output | 1 | Frame in progress |

## Verification
The hardest case to reach is a starved command queue in the middle of a frame. The sequencer must then go quiet with `busy` held, and the request flag must stay up without breaking the token order. The bench gets there by sending a first word that is not tagged message-end and holding the next word back for several cycles. It watches the token stream for silence, then releases a closing word and checks for a repeated START and a clean STOP. Option writes that should be ignored are timed the same way: they land just after the first word of a frame is accepted. Their absence is then shown by the arbitration header that appears in the following frame.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    TK_START  = 3'd0,
    TK_ARBHDR = 3'd1,
    TK_ADDR   = 3'd2,
    TK_DATA   = 3'd3,
    TK_EXIT   = 3'd4,
    TK_RSTPAT = 3'd5,
    TK_RSTART = 3'd6,
    TK_STOP   = 3'd7
  } tok_e;

  localparam logic [3:0] MT_HDR_ONLY = 4'b0001;
  localparam logic [3:0] MT_PRIV     = 4'b0010;
  localparam logic [3:0] MT_LEGACY   = 4'b0011;
  localparam logic [7:0] BCAST_WR    = 8'hFC;
endpackage

// File: rtl/fseq_cfg.sv
module fseq_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic role_in,
  input  logic opt_wr,
  input  logic no_arb_in,
  input  logic exit_in,
  input  logic rst_in,
  input  logic busy,
  output logic ctrl_active,
  output logic opt_no_arb,
  output logic opt_exit,
  output logic opt_rst
);
  logic en_q, role_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      role_q <= 1'b0;
    end else begin
      en_q <= enable;
      if (enable && !en_q) role_q <= role_in;
    end
  end

  assign ctrl_active = enable && en_q && role_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_no_arb <= 1'b0;
      opt_exit   <= 1'b0;
      opt_rst    <= 1'b0;
    end else if (opt_wr && !busy) begin
      opt_no_arb <= no_arb_in;
      opt_exit   <= exit_in;
      opt_rst    <= rst_in;
    end
  end

  AST_OPTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(opt_no_arb) && $stable(opt_exit) && $stable(opt_rst))); // R10
  AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q) |=> $stable(role_q)); // R11
endmodule

// File: rtl/fseq_req.sv
module fseq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_active,
  input  logic idle,
  input  logic sw_trigger,
  input  logic first_wr,
  input  logic first_wr_mend,
  input  logic cmd_valid,
  input  logic fetch_stall,
  input  logic accept,
  input  logic accept_mend,
  output logic need
);
  logic raise;
  assign raise = (idle && sw_trigger)
              || (idle && first_wr && !first_wr_mend && !cmd_valid)
              || fetch_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   need <= 1'b0;
    else if (!ctrl_active)        need <= 1'b0;
    else if (accept && accept_mend) need <= 1'b0;
    else if (raise)               need <= 1'b1;
  end

  AST_STALL_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && ctrl_active) |=> need); // R8
  AST_MEND_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_mend) |=> !need); // R6
endmodule

// File: rtl/fseq_core.sv
module fseq_core
  import fseq_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int TOKD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_active,
  input  logic              opt_no_arb,
  input  logic              opt_exit,
  input  logic              opt_rst,
  input  logic              preload,
  input  logic              cfifo_loaded,
  input  logic              txf_loaded,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_mend,
  input  logic [3:0]        cmd_mtype,
  input  logic              cmd_rstact,
  input  logic [6:0]        cmd_addr,
  input  logic              cmd_rnw,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              tok_valid,
  input  logic              tok_ready,
  output tok_e              tok_kind,
  output logic [TOKD_W-1:0] tok_data,
  output logic              busy,
  output logic              idle,
  output logic              fetch_stall,
  output logic              accept,
  output logic              accept_mend
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_BEG, S_ARB, S_ADR, S_DAT, S_EXT, S_RSP, S_STP
  } st_e;

  st_e              st, st_n;
  logic             first_q, rst_seen_q;
  logic             w_mend, w_rnw;
  logic [3:0]       w_mtype;
  logic [6:0]       w_addr;
  logic [LEN_W-1:0] w_len, idx;

  logic needs_tx, start_ok, last_byte, arb_ok;
  st_e  msg_done, beg_next, arb_next;

  assign needs_tx  = !cmd_rnw && (cmd_len != '0) && (cmd_mtype != MT_HDR_ONLY);
  assign start_ok  = cmd_valid && (!preload || (cfifo_loaded && (!needs_tx || txf_loaded)));
  assign last_byte = (idx == w_len - 1'b1);
  assign arb_ok    = first_q && !opt_no_arb && ((w_mtype == MT_PRIV) || (w_mtype == MT_LEGACY));

  assign msg_done  = w_mend ? ((opt_rst && rst_seen_q) ? S_RSP : S_STP) : S_FETCH;
  assign beg_next  = (w_mtype == MT_HDR_ONLY) ? S_ARB : (arb_ok ? S_ARB : S_ADR);
  assign arb_next  = (w_mtype == MT_HDR_ONLY) ? (opt_exit ? S_EXT : msg_done) : S_ADR;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:  if (start_ok)  st_n = S_FETCH;
      S_FETCH: if (cmd_valid) st_n = S_BEG;
      S_BEG:   if (tok_ready) st_n = beg_next;
      S_ARB:   if (tok_ready) st_n = arb_next;
      S_ADR:   if (tok_ready) st_n = (w_len != '0) ? S_DAT : msg_done;
      S_DAT:   if (tok_ready && last_byte) st_n = msg_done;
      S_EXT:   if (tok_ready) st_n = msg_done;
      S_RSP:   if (tok_ready) st_n = S_STP;
      S_STP:   if (tok_ready) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
    if (!ctrl_active) st_n = S_IDLE;
  end

  assign cmd_ready   = ctrl_active && (st == S_FETCH);
  assign accept      = cmd_ready && cmd_valid;
  assign accept_mend = accept && cmd_mend;
  assign fetch_stall = cmd_ready && !cmd_valid;
  assign busy        = (st != S_IDLE);
  assign idle        = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      first_q    <= 1'b1;
      rst_seen_q <= 1'b0;
      w_mend     <= 1'b0;
      w_rnw      <= 1'b0;
      w_mtype    <= '0;
      w_addr     <= '0;
      w_len      <= '0;
      idx        <= '0;
    end else begin
      st <= st_n;
      if (st == S_IDLE) begin
        first_q    <= 1'b1;
        rst_seen_q <= 1'b0;
      end
      if (accept) begin
        w_mend     <= cmd_mend;
        w_rnw      <= cmd_rnw;
        w_mtype    <= cmd_mtype;
        w_addr     <= cmd_addr;
        w_len      <= cmd_len;
        rst_seen_q <= rst_seen_q || cmd_rstact;
      end
      if (st == S_BEG && tok_ready) first_q <= 1'b0;
      if (st == S_ADR) idx <= '0;
      else if (st == S_DAT && tok_ready) idx <= idx + 1'b1;
    end
  end

  always_comb begin
    tok_valid = ctrl_active;
    tok_kind  = TK_START;
    tok_data  = '0;
    unique case (st)
      S_BEG: tok_kind = first_q ? TK_START : TK_RSTART;
      S_ARB: begin tok_kind = TK_ARBHDR; tok_data = TOKD_W'(BCAST_WR); end
      S_ADR: begin tok_kind = TK_ADDR;   tok_data = TOKD_W'({w_addr, w_rnw}); end
      S_DAT: begin tok_kind = TK_DATA;   tok_data = TOKD_W'(idx); end
      S_EXT: tok_kind = TK_EXIT;
      S_RSP: tok_kind = TK_RSTPAT;
      S_STP: tok_kind = TK_STOP;
      default: tok_valid = 1'b0;
    endcase
  end

  AST_TOKEN_HELD: assert property (@(posedge clk) disable iff (!rst_n || !ctrl_active)
    (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_kind) && $stable(tok_data))); // R12
  AST_STOP_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_kind == TK_STOP) |=> !busy); // R3
  AST_RSTPAT_BEFORE_STOP: assert property (@(posedge clk) disable iff (!rst_n || !ctrl_active)
    (tok_valid && tok_ready && tok_kind == TK_RSTPAT) |=> (tok_valid && tok_kind == TK_STOP)); // R4
  AST_NO_TOKEN_WHILE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tok_valid); // R8
endmodule

// File: rtl/ctl_frame_sequencer.sv
module ctl_frame_sequencer #(
  parameter int LEN_W = 8,
  localparam int TOKD_W = (LEN_W > 8) ? LEN_W : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_ctrl_role,
  input  logic              cfg_preload,
  input  logic              opt_wr,
  input  logic              opt_no_arb_in,
  input  logic              opt_exit_in,
  input  logic              opt_rst_in,
  input  logic              sw_trigger,
  input  logic              first_wr,
  input  logic              first_wr_mend,
  input  logic              cfifo_loaded,
  input  logic              txf_loaded,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_mend,
  input  logic [3:0]        cmd_mtype,
  input  logic              cmd_rstact,
  input  logic [6:0]        cmd_addr,
  input  logic              cmd_rnw,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              tok_valid,
  input  logic              tok_ready,
  output logic [2:0]        tok_kind,
  output logic [TOKD_W-1:0] tok_data,
  output logic              need_word,
  output logic              busy
);
  logic ctrl_active, opt_no_arb, opt_exit, opt_rst;
  logic idle, fetch_stall, accept, accept_mend;
  fseq_pkg::tok_e kind_e;

  fseq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .role_in(cfg_ctrl_role),
    .opt_wr(opt_wr), .no_arb_in(opt_no_arb_in), .exit_in(opt_exit_in),
    .rst_in(opt_rst_in), .busy(busy), .ctrl_active(ctrl_active),
    .opt_no_arb(opt_no_arb), .opt_exit(opt_exit), .opt_rst(opt_rst)
  );

  fseq_core #(.LEN_W(LEN_W), .TOKD_W(TOKD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl_active(ctrl_active),
    .opt_no_arb(opt_no_arb), .opt_exit(opt_exit), .opt_rst(opt_rst),
    .preload(cfg_preload), .cfifo_loaded(cfifo_loaded), .txf_loaded(txf_loaded),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mend(cmd_mend),
    .cmd_mtype(cmd_mtype), .cmd_rstact(cmd_rstact), .cmd_addr(cmd_addr),
    .cmd_rnw(cmd_rnw), .cmd_len(cmd_len), .tok_valid(tok_valid),
    .tok_ready(tok_ready), .tok_kind(kind_e), .tok_data(tok_data), .busy(busy),
    .idle(idle), .fetch_stall(fetch_stall), .accept(accept), .accept_mend(accept_mend)
  );

  fseq_req u_req (
    .clk(clk), .rst_n(rst_n), .ctrl_active(ctrl_active), .idle(idle),
    .sw_trigger(sw_trigger), .first_wr(first_wr), .first_wr_mend(first_wr_mend),
    .cmd_valid(cmd_valid), .fetch_stall(fetch_stall), .accept(accept),
    .accept_mend(accept_mend), .need(need_word)
  );

  assign tok_kind = kind_e;

  AST_TARGET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_active |=> (!need_word)); // R11
endmodule

// File: tb/sim_ctl_frame_sequencer.sv
`timescale 1ns/1ps
module sim_ctl_frame_sequencer;
  localparam logic [3:0] HDR = 4'b0001, PRV = 4'b0010, LEG = 4'b0011, CCC = 4'b0110;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_ctrl_role = 1, cfg_preload = 0;
  logic opt_wr = 0, opt_no_arb_in = 0, opt_exit_in = 0, opt_rst_in = 0;
  logic sw_trigger = 0, first_wr = 0, first_wr_mend = 0;
  logic cfifo_loaded = 0, txf_loaded = 0;
  logic cmd_valid = 0, cmd_mend = 0, cmd_rstact = 0, cmd_rnw = 0;
  logic [3:0] cmd_mtype = 0;
  logic [6:0] cmd_addr = 0;
  logic [7:0] cmd_len = 0;
  logic cmd_ready, tok_valid, need_word, busy;
  logic tok_ready = 1;
  logic [2:0] tok_kind;
  logic [7:0] tok_data;

  always #5 clk = ~clk;

  ctl_frame_sequencer u0 (.*);

  int checks = 0, errors = 0, hchk = 0, herr = 0;
  logic [2:0] log_k [0:511];
  logic [7:0] log_d [0:511];
  int log_n = 0;
  logic [2:0] exp_k [0:31];
  logic [7:0] exp_d [0:31];
  int exp_n = 0, log_base = 0;
  bit toggle_rdy = 0, timeout = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 tok_ready = toggle_rdy ? cyc[0] : 1'b1;
  end

  logic pv = 0; logic [2:0] pk; logic [7:0] pd;
  always @(negedge clk) begin
    if (pv) begin
      hchk++;
      if (!(tok_valid && tok_kind == pk && tok_data == pd)) begin
        herr++;
        $display("FAIL R12 held token changed: act v%0d k%0d d%0h exp k%0d d%0h",
                 tok_valid, tok_kind, tok_data, pk, pd);
      end
    end
    pv = tok_valid && !tok_ready && rst_n;
    pk = tok_kind; pd = tok_data;
    if (tok_valid && tok_ready && log_n < 512) begin
      log_k[log_n] = tok_kind; log_d[log_n] = tok_data; log_n++;
    end
  end

  task automatic chk(input string r, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", r, act, exp); end
  endtask

  task automatic exp_clear(); exp_n = 0; log_base = log_n; endtask
  task automatic ex(input logic [2:0] k, input logic [7:0] d);
    exp_k[exp_n] = k; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic cmp(input string r);
    int n = log_n - log_base;
    chk({r, " token count"}, n == exp_n, n, exp_n);
    for (int i = 0; i < exp_n && i < n; i++) begin
      chk({r, " token kind"}, log_k[log_base+i] == exp_k[i], log_k[log_base+i], exp_k[i]);
      chk({r, " token data"}, log_d[log_base+i] == exp_d[i], log_d[log_base+i], exp_d[i]);
    end
  endtask

  task automatic send_word(input logic m, input logic [3:0] t, input logic ra,
                           input logic [6:0] a, input logic rw, input logic [7:0] l);
    @(negedge clk);
    cmd_mend = m; cmd_mtype = t; cmd_rstact = ra; cmd_addr = a; cmd_rnw = rw; cmd_len = l;
    cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_opts(input logic na, input logic ex_o, input logic rs);
    @(negedge clk);
    opt_no_arb_in = na; opt_exit_in = ex_o; opt_rst_in = rs; opt_wr = 1;
    @(negedge clk); opt_wr = 0;
  endtask

  task automatic t_reset();
    chk("R13 busy", busy == 0, busy, 0);
    chk("R13 tok_valid", tok_valid == 0, tok_valid, 0);
    chk("R13 cmd_ready", cmd_ready == 0, cmd_ready, 0);
    chk("R13 need_word", need_word == 0, need_word, 0);
  endtask

  task automatic t_basic();
    toggle_rdy = 1;
    exp_clear();
    send_word(0, PRV, 0, 7'h52, 0, 2);
    send_word(1, LEG, 0, 7'h21, 1, 1);
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(2,8'hA4); ex(3,0); ex(3,1);
    ex(6,0); ex(2,8'h43); ex(3,0); ex(7,0);
    cmp("R1 R2 R3 two-message frame");
    toggle_rdy = 0;
  endtask

  task automatic t_noarb();
    exp_clear();
    send_word(1, CCC, 0, 7'h7E, 0, 1);
    wait_idle();
    ex(0,0); ex(2,8'hFC); ex(3,0); ex(7,0);
    cmp("R1 other type no header");
    set_opts(1, 0, 0);
    exp_clear();
    send_word(1, PRV, 0, 7'h10, 1, 0);
    wait_idle();
    ex(0,0); ex(2,8'h21); ex(7,0);
    cmp("R1 option suppresses header");
    set_opts(0, 0, 0);
  endtask

  task automatic t_rstpat();
    set_opts(0, 0, 1);
    exp_clear();
    send_word(0, CCC, 1, 7'h7E, 0, 1);
    send_word(1, PRV, 0, 7'h33, 0, 0);
    wait_idle();
    ex(0,0); ex(2,8'hFC); ex(3,0); ex(6,0); ex(2,8'h66); ex(5,0); ex(7,0);
    cmp("R4 reset pattern inserted");
    exp_clear();
    send_word(1, LEG, 0, 7'h33, 0, 0);
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(2,8'h66); ex(7,0);
    cmp("R4 no reset action no pattern");
    set_opts(0, 0, 0);
    exp_clear();
    send_word(1, CCC, 1, 7'h7E, 0, 0);
    wait_idle();
    ex(0,0); ex(2,8'hFC); ex(7,0);
    cmp("R4 option clear plain stop");
  endtask

  task automatic t_exit();
    set_opts(0, 1, 0);
    exp_clear();
    send_word(1, HDR, 0, 7'h00, 0, 0);
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(4,0); ex(7,0);
    cmp("R5 exit pattern after header");
    set_opts(0, 0, 0);
    exp_clear();
    send_word(1, HDR, 0, 7'h00, 0, 0);
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(7,0);
    cmp("R5 no exit pattern");
  endtask

  task automatic t_ignore();
    exp_clear();
    send_word(0, PRV, 0, 7'h05, 1, 0);
    chk("R10 busy during write", busy == 1, busy, 1);
    set_opts(1, 1, 1);
    send_word(1, PRV, 0, 7'h06, 1, 0);
    wait_idle();
    exp_clear();
    send_word(1, PRV, 0, 7'h07, 1, 0);
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(2,8'h0F); ex(7,0);
    cmp("R10 option write in frame ignored");
  endtask

  task automatic t_trig();
    @(negedge clk);
    chk("R6 flag low before trigger", need_word == 0, need_word, 0);
    sw_trigger = 1; @(negedge clk); sw_trigger = 0;
    chk("R6 flag after trigger", need_word == 1, need_word, 1);
    chk("R6 still idle", busy == 0, busy, 0);
    send_word(0, LEG, 0, 7'h01, 1, 0);
    @(negedge clk);
    chk("R6 flag held after non-end word", need_word == 1, need_word, 1);
    send_word(1, LEG, 0, 7'h02, 1, 0);
    @(negedge clk);
    chk("R6 flag cleared by end word", need_word == 0, need_word, 0);
    wait_idle();
  endtask

  task automatic t_first();
    @(negedge clk);
    first_wr = 1; first_wr_mend = 0; @(negedge clk); first_wr = 0;
    chk("R7 flag after first write", need_word == 1, need_word, 1);
    send_word(0, PRV, 0, 7'h08, 1, 0);
    send_word(1, PRV, 0, 7'h09, 1, 0);
    wait_idle();
    chk("R7 flag cleared", need_word == 0, need_word, 0);
    @(negedge clk);
    first_wr = 1; first_wr_mend = 1; @(negedge clk); first_wr = 0;
    chk("R7 end-tagged first write no flag", need_word == 0, need_word, 0);
    send_word(1, PRV, 0, 7'h0A, 1, 0);
    wait_idle();
  endtask

  task automatic t_stall();
    int n0;
    exp_clear();
    send_word(0, PRV, 0, 7'h11, 1, 0);
    repeat (6) @(negedge clk);
    n0 = log_n;
    repeat (8) @(negedge clk);
    chk("R8 no tokens while starved", log_n == n0, log_n, n0);
    chk("R8 tok_valid low", tok_valid == 0, tok_valid, 0);
    chk("R8 busy held", busy == 1, busy, 1);
    chk("R8 flag high", need_word == 1, need_word, 1);
    send_word(1, LEG, 0, 7'h12, 0, 0);
    chk("R8 flag cleared on arrival", need_word == 0, need_word, 0);
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(2,8'h23); ex(6,0); ex(2,8'h24); ex(7,0);
    cmp("R8 resumed frame");
  endtask

  task automatic t_preload();
    exp_clear();
    cfg_preload = 1;
    @(negedge clk);
    cmd_mend = 1; cmd_mtype = PRV; cmd_rstact = 0; cmd_addr = 7'h0A; cmd_rnw = 0; cmd_len = 2;
    cmd_valid = 1;
    repeat (5) @(negedge clk);
    chk("R9 waits for command queue", busy == 0 && log_n == log_base, busy, 0);
    cfifo_loaded = 1;
    repeat (5) @(negedge clk);
    chk("R9 waits for transmit queue", busy == 0 && log_n == log_base, busy, 0);
    txf_loaded = 1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 0;
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(2,8'h14); ex(3,0); ex(3,1); ex(7,0);
    cmp("R9 preloaded write frame");
    txf_loaded = 0;
    exp_clear();
    send_word(1, PRV, 0, 7'h0B, 1, 0);
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(2,8'h17); ex(7,0);
    cmp("R9 read needs no transmit preload");
    cfg_preload = 0; cfifo_loaded = 0;
  endtask

  task automatic t_target();
    @(negedge clk); cfg_enable = 0; cfg_ctrl_role = 0;
    @(negedge clk); cfg_enable = 1;
    repeat (2) @(negedge clk);
    exp_clear();
    cmd_mend = 1; cmd_mtype = PRV; cmd_rstact = 0; cmd_addr = 7'h11; cmd_rnw = 1; cmd_len = 0;
    cmd_valid = 1;
    sw_trigger = 1; @(negedge clk); sw_trigger = 0;
    repeat (6) @(negedge clk);
    chk("R11 target emits nothing", log_n == log_base, log_n - log_base, 0);
    chk("R11 target cmd_ready low", cmd_ready == 0, cmd_ready, 0);
    chk("R11 target flag low", need_word == 0, need_word, 0);
    cfg_ctrl_role = 1;
    repeat (4) @(negedge clk);
    chk("R11 role change ignored while enabled", log_n == log_base && busy == 0, busy, 0);
    cfg_enable = 0; @(negedge clk); cfg_enable = 1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 0;
    wait_idle();
    ex(0,0); ex(1,8'hFC); ex(2,8'h23); ex(7,0);
    cmp("R11 controller after re-enable");
  endtask

  task automatic run_all();
    t_reset();
    @(negedge clk); cfg_enable = 1;
    repeat (3) @(negedge clk);
    t_basic(); t_noarb(); t_rstpat(); t_exit(); t_ignore();
    t_trig(); t_first(); t_stall(); t_preload(); t_target();
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog act=1 exp=0");
    end
    checks += hchk; errors += herr;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule